// File: doc/BRIEF.md
# Bus Clock Band Classifier and PLL Tuning Controller

This block takes a measured bus-clock count and a scaling constant and works out which of four frequency bands the bus runs in: nominally 33, 40, 50 or 66 MHz. It then drives a tuning sequence for an on-chip digital PLL. From the band and the chosen PLL target it computes a pair of frequency bounds. It raises a tuning enable and watches the PLL lock bit. Lock only counts once it has held for a full window of consecutive samples.

If an attempt times out, or lock drops during the hold window, the controller widens the bounds and tries again. Odd-numbered retries lower the low bound and even-numbered retries raise the high bound, each by a step that grows with the attempt number. After the last allowed attempt fails, the controller reports an error. On success it clears tuning enable and reports done. Software or a boot sequencer pulses `start` and waits for `done` or `err`. It then reads the band and the packed control word.

Top module: `bclk_tune_ctrl`

## Requirements
- R1: After reset, busy, done, err and tune_en are all 0.
- R2: With f = floor(base_k × freq_cnt / 192), the band is 0 for f < 40, 1 for 40 ≤ f < 45, 2 for 45 ≤ f < 55 and 3 for f ≥ 55. The band codes mean 33, 40, 50 and 66 MHz.
- R3: The PLL target is 66 MHz when hi_target is 1 and 50 MHz otherwise. The initial low bound is floor(band MHz × 48 / target MHz).
- R4: The initial high bound is the low bound + 2. When the band code is 2 or 3, a further 2 is added.
- R5: ctl_word carries hi_bound in bits 31:16, lo_bound in bits 7:0 and tune_en in bit 8. All other bits are 0.
- R6: tune_en is 1 from the cycle after the bounds load until lock is confirmed. Confirmed lock clears it.
- R7: Once lock is first sampled in an attempt, it must be sampled high on HOLD_LIMIT further consecutive samples. One low sample in that window fails the attempt.
- R8: Lock is sampled once every POLL_GAP clocks. An attempt that sees no lock within POLL_LIMIT samples fails.
- R9: After failed attempt k (counted from 0), an odd k subtracts k>>1 from the low bound and an even k adds k>>1 to the high bound. The bounds do not change at any other time during a run.
- R10: When attempt MAX_TRY−1 fails, err is raised and the adjusted bounds are kept. tune_en stays 1.
- R11: busy is 1 from the cycle after an accepted start until done or err rises. done and err are never 1 together, and they hold until the next start.
- R12: A start pulse while busy is ignored: the run continues with the inputs captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that captures the inputs and begins a run |
| freq_cnt | input | 9 | Measured bus-clock count |
| base_k | input | 8 | Scaling constant applied to the count |
| hi_target | input | 1 | 1 selects the 66 MHz PLL target, 0 selects 50 MHz |
| pll_lock | input | 1 | PLL lock status |
| busy | output | 1 | A run is in progress |
| band | output | 2 | Band code of the last accepted run |
| lo_bound | output | 16 | Current low frequency bound |
| hi_bound | output | 16 | Current high frequency bound |
| ctl_word | output | 32 | Packed bounds and tuning enable |
| tune_en | output | 1 | PLL tuning enable |
| done | output | 1 | Calibration succeeded |
| err | output | 1 | All attempts failed |

## Verification
On every cycle, the assertions check the following:
- The direction and size of each bound adjustment after a failed attempt.
- The stillness of the bounds between failures.
- That a pass needs lock and clears tuning.
- That the last failure raises err.
- That a start during a run leaves the band alone.

The bench's scenarios cover what those local checks cannot. These are the band thresholds at their exact edges, and the bound values for both targets. They also cover the overall run length set by the poll and hold windows. Finally, they cover the end-to-end outcome of a lock that only appears after several widenings or that keeps glitching inside the hold window.

// File: rtl/bclk_tune_pkg.sv
package bclk_tune_pkg;

  localparam int CNT_W  = 9;
  localparam int BASE_W = 8;
  localparam int BND_W  = 16;
  localparam int PROD_W = CNT_W + BASE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ARM,
    ST_RUN,
    ST_PASS,
    ST_FAIL
  } tune_st_e;

  // band code from the scaled count
  function automatic logic [1:0] band_of(input logic [CNT_W-1:0] cnt,
                                         input logic [BASE_W-1:0] base);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] mhz;
    prod = PROD_W'(base) * PROD_W'(cnt);
    mhz  = prod / PROD_W'(192);
    if (mhz < PROD_W'(40))      return 2'd0;
    else if (mhz < PROD_W'(45)) return 2'd1;
    else if (mhz < PROD_W'(55)) return 2'd2;
    else                        return 2'd3;
  endfunction

  function automatic logic [BND_W-1:0] band_mhz(input logic [1:0] b);
    case (b)
      2'd0:    return BND_W'(33);
      2'd1:    return BND_W'(40);
      2'd2:    return BND_W'(50);
      default: return BND_W'(66);
    endcase
  endfunction

  function automatic logic [BND_W-1:0] low_of(input logic [1:0] b,
                                              input logic hit);
    logic [BND_W-1:0] tgt;
    tgt = hit ? BND_W'(66) : BND_W'(50);
    return (band_mhz(b) * BND_W'(48)) / tgt;
  endfunction

  function automatic logic [BND_W-1:0] high_of(input logic [1:0] b,
                                               input logic [BND_W-1:0] lo);
    return lo + BND_W'(2) + ((b > 2'd1) ? BND_W'(2) : BND_W'(0));
  endfunction

  // widening step after failed attempt k
  function automatic logic [BND_W-1:0] step_of(input int unsigned k);
    return BND_W'(k >> 1);
  endfunction

endpackage

// File: rtl/bclk_band_calc.sv
module bclk_band_calc
  import bclk_tune_pkg::*;
(
  input  logic [CNT_W-1:0]  cnt,
  input  logic [BASE_W-1:0] base,
  input  logic              hit,
  output logic [1:0]        band,
  output logic [BND_W-1:0]  lo,
  output logic [BND_W-1:0]  hi
);

  always_comb begin
    band = band_of(cnt, base);
    lo   = low_of(band, hit);
    hi   = high_of(band, lo);
  end

endmodule

// File: rtl/bclk_sample_timer.sv
module bclk_sample_timer #(
  parameter int POLL_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int TW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;

  logic [TW-1:0] gap_cnt;

  assign tick = en && (gap_cnt == TW'(POLL_GAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gap_cnt <= '0;
    else if (!en || tick)   gap_cnt <= '0;
    else                    gap_cnt <= gap_cnt + TW'(1);
  end

  generate
    if (POLL_GAP > 1) begin : g_gap_chk
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R8
    end
  endgenerate

endmodule

// File: rtl/bclk_lock_judge.sv
module bclk_lock_judge #(
  parameter int POLL_LIMIT = 20480,
  parameter int HOLD_LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  input  logic lock,
  output logic pass_evt,
  output logic fail_evt
);

  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int HW = (HOLD_LIMIT > 1) ? $clog2(HOLD_LIMIT) : 1;

  logic          active;
  logic          holding;
  logic [PW-1:0] poll_cnt;
  logic [HW-1:0] hold_cnt;
  logic          smp;
  logic          poll_last;
  logic          hold_last;

  assign smp       = active && tick;
  assign poll_last = (poll_cnt == PW'(POLL_LIMIT - 1));
  assign hold_last = (hold_cnt == HW'(HOLD_LIMIT - 1));

  assign pass_evt = smp && holding && lock && hold_last;
  assign fail_evt = smp && ((holding && !lock) || (!holding && !lock && poll_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      holding  <= 1'b0;
      poll_cnt <= '0;
      hold_cnt <= '0;
    end else if (arm) begin
      active   <= 1'b1;
      holding  <= 1'b0;
      poll_cnt <= '0;
      hold_cnt <= '0;
    end else if (pass_evt || fail_evt) begin
      active   <= 1'b0;
      holding  <= 1'b0;
    end else if (smp) begin
      if (holding) begin
        hold_cnt <= hold_cnt + HW'(1);
      end else if (lock) begin
        holding  <= 1'b1;
        hold_cnt <= '0;
      end else begin
        poll_cnt <= poll_cnt + PW'(1);
      end
    end
  end

  AST_PASS_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pass_evt |-> lock); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_evt && fail_evt)); // R7
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(pass_evt || fail_evt)); // R8

endmodule

// File: rtl/bclk_tune_ctrl.sv
module bclk_tune_ctrl
  import bclk_tune_pkg::*;
#(
  parameter int POLL_LIMIT = 20480,
  parameter int HOLD_LIMIT = 4096,
  parameter int MAX_TRY    = 8,
  parameter int POLL_GAP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  freq_cnt,
  input  logic [BASE_W-1:0] base_k,
  input  logic              hi_target,
  input  logic              pll_lock,
  output logic              busy,
  output logic [1:0]        band,
  output logic [BND_W-1:0]  lo_bound,
  output logic [BND_W-1:0]  hi_bound,
  output logic [31:0]       ctl_word,
  output logic              tune_en,
  output logic              done,
  output logic              err
);

  localparam int TRY_W = (MAX_TRY > 1) ? $clog2(MAX_TRY) : 1;

  tune_st_e          st;
  logic [CNT_W-1:0]  cnt_q;
  logic [BASE_W-1:0] base_q;
  logic              hit_q;
  logic [TRY_W-1:0]  try_q;
  logic [1:0]        calc_band;
  logic [BND_W-1:0]  calc_lo;
  logic [BND_W-1:0]  calc_hi;
  logic              idle_like;
  logic              accept;
  logic              arm;
  logic              tick;
  logic              pass_evt;
  logic              fail_evt;
  logic              last_try;
  logic [BND_W-1:0]  step;

  bclk_band_calc u_calc (
    .cnt  (cnt_q),
    .base (base_q),
    .hit  (hit_q),
    .band (calc_band),
    .lo   (calc_lo),
    .hi   (calc_hi)
  );

  bclk_sample_timer #(.POLL_GAP(POLL_GAP)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (st == ST_RUN),
    .tick  (tick)
  );

  bclk_lock_judge #(.POLL_LIMIT(POLL_LIMIT), .HOLD_LIMIT(HOLD_LIMIT)) u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .tick     (tick),
    .lock     (pll_lock),
    .pass_evt (pass_evt),
    .fail_evt (fail_evt)
  );

  assign idle_like = (st == ST_IDLE) || (st == ST_PASS) || (st == ST_FAIL);
  assign accept    = idle_like && start;
  assign arm       = (st == ST_LOAD) || (st == ST_ARM);
  assign last_try  = (try_q == TRY_W'(MAX_TRY - 1));
  assign step      = step_of(32'(try_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      base_q <= '0;
      hit_q  <= 1'b0;
    end else if (accept) begin
      cnt_q  <= freq_cnt;
      base_q <= base_k;
      hit_q  <= hi_target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      band     <= 2'd0;
      lo_bound <= '0;
      hi_bound <= '0;
      tune_en  <= 1'b0;
      try_q    <= '0;
    end else begin
      case (st)
        ST_LOAD: begin
          band     <= calc_band;
          lo_bound <= calc_lo;
          hi_bound <= calc_hi;
          tune_en  <= 1'b1;
          try_q    <= '0;
          st       <= ST_RUN;
        end
        ST_ARM: st <= ST_RUN;
        ST_RUN: begin
          if (pass_evt) begin
            tune_en <= 1'b0;
            st      <= ST_PASS;
          end else if (fail_evt) begin
            if (try_q[0]) lo_bound <= lo_bound - step;
            else          hi_bound <= hi_bound + step;
            if (last_try) begin
              st <= ST_FAIL;
            end else begin
              try_q <= try_q + TRY_W'(1);
              st    <= ST_ARM;
            end
          end
        end
        default: if (start) st <= ST_LOAD;
      endcase
    end
  end

  assign busy     = (st == ST_LOAD) || (st == ST_ARM) || (st == ST_RUN);
  assign done     = (st == ST_PASS);
  assign err      = (st == ST_FAIL);
  assign ctl_word = {hi_bound, 7'd0, tune_en, lo_bound[7:0]};

  AST_PASS_CLEARS_TUNE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_evt && (st == ST_RUN) |=> done && !tune_en); // R6
  AST_LAST_FAIL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt && (st == ST_RUN) && last_try |=> err && tune_en); // R10
  AST_ODD_LOWERS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt && (st == ST_RUN) && try_q[0] |=>
      (hi_bound == $past(hi_bound)) && (lo_bound == $past(lo_bound) - $past(step))); // R9
  AST_EVEN_RAISES_HI: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt && (st == ST_RUN) && !try_q[0] |=>
      (lo_bound == $past(lo_bound)) && (hi_bound == $past(hi_bound) + $past(step))); // R9
  AST_BOUNDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) && !fail_evt |=> $stable(lo_bound) && $stable(hi_bound)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) && start |=> $stable(band)); // R12
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, err})); // R11
  AST_LO_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    lo_bound < BND_W'(256)); // R5

endmodule

// File: tb/bclk_tune_ctrl_tb.sv
module bclk_tune_ctrl_tb;

  localparam int PL  = 40;
  localparam int HL  = 16;
  localparam int MT  = 8;
  localparam int GAP = 2;

  typedef struct {
    int    band;
    int    lo;
    int    hi;
    bit    ok;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  freq_cnt = '0;
  logic [7:0]  base_k = '0;
  logic        hi_target = 1'b0;
  logic        pll_lock = 1'b0;
  logic        busy, tune_en, done, err;
  logic [1:0]  band;
  logic [15:0] lo_bound, hi_bound;
  logic [31:0] ctl_word;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc = 0;
  int  lock_mode = 0;
  int  lock_thr = 0;
  bit  got = 1'b1;
  int  fin_cyc = 0;
  bit  finished = 1'b0;
  exp_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bclk_tune_ctrl #(.POLL_LIMIT(PL), .HOLD_LIMIT(HL), .MAX_TRY(MT), .POLL_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_cnt(freq_cnt), .base_k(base_k),
    .hi_target(hi_target), .pll_lock(pll_lock), .busy(busy), .band(band),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .ctl_word(ctl_word),
    .tune_en(tune_en), .done(done), .err(err));

  // PLL model: 0 never locks, 1 locks, 2 locks once hi bound reaches threshold, 3 glitches
  always @(negedge clk) begin
    case (lock_mode)
      1: pll_lock <= 1'b1;
      2: pll_lock <= (int'(hi_bound) >= lock_thr);
      3: pll_lock <= ((cyc % 20) >= 3);
      default: pll_lock <= 1'b0;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(input int cnt, input int base, input bit hit,
                                   input int mode, input int thr, input string tag);
    exp_t e;
    int prod, mhz, tgt;
    prod = base * cnt;
    if (prod < 7680)       e.band = 0;
    else if (prod < 8640)  e.band = 1;
    else if (prod < 10560) e.band = 2;
    else                   e.band = 3;
    mhz = (e.band == 0) ? 33 : (e.band == 1) ? 40 : (e.band == 2) ? 50 : 66;
    tgt = hit ? 66 : 50;
    e.lo = (mhz * 48) / tgt;
    e.hi = e.lo + ((e.band >= 2) ? 4 : 2);
    e.ok = 1'b0;
    e.tag = tag;
    for (int k = 0; k < MT; k++) begin
      if (mode == 1 || (mode == 2 && e.hi >= thr)) begin
        e.ok = 1'b1;
        break;
      end
      if (k % 2 == 1) e.lo = e.lo - k / 2;
      else            e.hi = e.hi + k / 2;
    end
    return e;
  endfunction

  // monitor: pops one expected item per finished run
  always @(negedge clk) begin
    if (rst_n && (done || err) && !got && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      got = 1'b1;
      fin_cyc = cyc;
      chk(int'(band) == e.band, {"R2 band ", e.tag}, int'(band), e.band);
      chk(int'(lo_bound) == e.lo, {"R3 R9 lo ", e.tag}, int'(lo_bound), e.lo);
      chk(int'(hi_bound) == e.hi, {"R4 R9 hi ", e.tag}, int'(hi_bound), e.hi);
      chk(done == e.ok && err == !e.ok, {"R10 outcome ", e.tag}, int'(done), int'(e.ok));
      chk(ctl_word == {e.hi[15:0], 7'd0, !e.ok, e.lo[7:0]}, {"R5 R6 word ", e.tag},
          int'(ctl_word), int'({e.hi[15:0], 7'd0, !e.ok, e.lo[7:0]}));
    end
  end

  task automatic run_case(input int cnt, input int base, input bit hit, input int mode,
                          input int thr, input string tag, input bit poke, output int dur);
    exp_t e;
    int t0;
    e = predict(cnt, base, hit, mode, thr, tag);
    lock_mode = mode;
    lock_thr  = thr;
    @(negedge clk);
    freq_cnt = 9'(cnt); base_k = 8'(base); hi_target = hit; start = 1'b1;
    t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    sb_q.push_back(e);
    got = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, {"R11 busy mid-run ", tag}, int'(busy), 1);
    chk(tune_en == 1'b1 && ctl_word[8] == 1'b1, {"R6 tune on mid-run ", tag}, int'(tune_en), 1);
    if (poke) begin
      // R12: new inputs and start while busy must not disturb the run
      freq_cnt = 9'd20; base_k = 8'd10; hi_target = !hit; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (got == 1'b1);
    dur = fin_cyc - t0;
    repeat (4) @(negedge clk);
    chk((done || err) && !busy, {"R11 result held ", tag}, int'(done || err), 1);
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !tune_en, "R1 reset outputs", int'({busy, done, err, tune_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !tune_en, "R1 after reset", int'({busy, done, err, tune_en}), 0);

    run_case(159, 48, 1'b0, 1, 0, "R2 f39 band0", 1'b0, d);
    chk(d >= (HL + 1) * GAP && d <= (HL + 1) * GAP + 6, "R7 R8 hold duration", d, (HL + 1) * GAP);
    run_case(160, 48, 1'b1, 1, 0, "R2 f40 band1", 1'b0, d);
    run_case(179, 48, 1'b0, 1, 0, "R2 f44 band1", 1'b0, d);
    run_case(180, 48, 1'b1, 1, 0, "R2 f45 band2", 1'b0, d);
    run_case(219, 48, 1'b0, 1, 0, "R2 f54 band2", 1'b0, d);
    run_case(220, 48, 1'b1, 1, 0, "R2 f55 band3", 1'b0, d);
    run_case(300, 66, 1'b0, 1, 0, "R3 band3 tgt50", 1'b0, d);

    run_case(133, 48, 1'b0, 0, 0, "R8 R10 never lock", 1'b0, d);
    chk(d >= MT * PL * GAP && d <= MT * PL * GAP + MT * 6, "R8 timeout duration", d, MT * PL * GAP);

    run_case(200, 48, 1'b1, 3, 0, "R7 glitch in hold", 1'b0, d);

    run_case(133, 48, 1'b0, 2, 36, "R9 late lock", 1'b0, d);

    run_case(220, 48, 1'b1, 1, 0, "R12 start ignored", 1'b1, d);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule